// File: doc/BRIEF.md
# Per-Bank Bit-Granular Write Mask Unit

This block sits in the write path of a two-bank, 32-bit graphics memory model. For every write beat it computes the enable vector that tells the storage array which bits to update. The computation combines two masks. The first is the per-byte data mask driven with the write. The second is a programmable bit mask, which applies only when bit masking is armed for the bank being written.

Each bank has its own arm flag. The flag is set or cleared by the level of the special-function strobe when that bank is activated. The bit mask is one shared register, loaded from the data pins by the special register-load command. Single writes, each beat of a burst and block writes are all handled the same way: every beat with `wr_i` high produces one enable vector. The vector is registered and appears on the cycle after the beat is sampled.

Top module: `wpb_mask_unit`

## Requirements
- R1: Synchronous reset (active-high `rst`) clears both arm flags, sets the bit mask register to all ones and drives `bit_en_o` to zero and `bit_en_vld_o` low.
- R2: A cycle with `act_i` high arms bit masking for bank `bank_i` when `dsf_i` is 1 and disarms it when `dsf_i` is 0.
- R3: An activate changes only the flag of the selected bank; the other bank's flag keeps its value.
- R4: A cycle with `smrs_i` high loads `dq_i` into the bit mask register, and writes issued in later cycles use the new mask.
- R5: A write to an armed bank yields, for each bit i, enable = mask[i] AND NOT dqm_i[i/8]. Mask bit 1 means write; mask bit 0 means keep the stored bit. `dqm_i` bit b = 1 blocks bits 8b..8b+7.
- R6: A write to a disarmed bank yields an enable that depends only on the byte masks: bit i = NOT dqm_i[i/8].
- R7: `bit_en_o` and `bit_en_vld_o` are registered. A write sampled at clock edge k shows its result after edge k+1's predecessor, that is, it is visible from edge k until edge k+1. After a cycle with `wr_i` low, `bit_en_vld_o` is 0 and `bit_en_o` is zero.
- R8: When a write shares its cycle with a mask load or with an activate, the write uses the mask and the flags as they stood before that cycle.
- R9: Back-to-back write beats, as in a burst or block write, each produce their own enable with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_i | input | 1 | Bank activate command |
| wr_i | input | 1 | Write beat command |
| smrs_i | input | 1 | Special register-load command (loads bit mask) |
| bank_i | input | 1 | Bank select |
| dsf_i | input | 1 | Special-function strobe, sampled on activate |
| dq_i | input | 32 | Data pins, mask source on register load |
| dqm_i | input | 4 | Byte masks, 1 blocks the byte |
| bit_en_o | output | 32 | Registered per-bit write enable |
| bit_en_vld_o | output | 1 | High when bit_en_o belongs to a write |

## Verification
A write can share its cycle with a mask load or with an activate of the bank it targets. In both cases the write must use the state from before that cycle. The bench creates these collisions directly: one cycle carries both a load and a write, and another carries both an activate and a write to the same bank. Its behavioural model updates state only after it has computed the expected enable. A following write then shows whether the new mask or flag took effect. Random command mixes add further accidental collisions, and every cycle is compared.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
  localparam int DEF_DATA_W    = 32;
  localparam int DEF_BYTE_W    = 8;
  localparam int DEF_NUM_BANKS = 2;

  typedef struct packed {
    logic act;
    logic wr;
    logic smrs;
  } wpb_cmd_t;
endpackage

// File: rtl/wpb_mask_reg.sv
module wpb_mask_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst)         mask_o <= '1;
    else if (load_i) mask_o <= data_i;
  end
endmodule

// File: rtl/wpb_bank_flags.sv
module wpb_bank_flags #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 act_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 dsf_i,
  output logic [NUM_BANKS-1:0] flags_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = act_i && (bank_i == BANK_W'(b));
    always_ff @(posedge clk) begin
      if (rst)      flags_o[b] <= 1'b0;
      else if (hit) flags_o[b] <= dsf_i;
    end
  end
endmodule

// File: rtl/wpb_enable_gen.sv
module wpb_enable_gen #(
  parameter int DATA_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = DATA_W / BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_i,
  input  logic                 wpb_on_i,
  input  logic [DATA_W-1:0]    mask_i,
  input  logic [NUM_BYTES-1:0] dqm_i,
  output logic [DATA_W-1:0]    bit_en_o,
  output logic                 vld_o
);
  logic [DATA_W-1:0] byte_keep;
  logic [DATA_W-1:0] bit_keep;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    assign byte_keep[b*BYTE_W +: BYTE_W] = {BYTE_W{~dqm_i[b]}};
  end

  assign bit_keep = wpb_on_i ? mask_i : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_en_o <= '0;
      vld_o    <= 1'b0;
    end else begin
      vld_o    <= wr_i;
      bit_en_o <= wr_i ? (byte_keep & bit_keep) : '0;
    end
  end
endmodule

// File: rtl/wpb_mask_unit.sv
module wpb_mask_unit #(
  parameter int DATA_W    = wpb_pkg::DEF_DATA_W,
  parameter int BYTE_W    = wpb_pkg::DEF_BYTE_W,
  parameter int NUM_BANKS = wpb_pkg::DEF_NUM_BANKS,
  localparam int NUM_BYTES = DATA_W / BYTE_W,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 act_i,
  input  logic                 wr_i,
  input  logic                 smrs_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 dsf_i,
  input  logic [DATA_W-1:0]    dq_i,
  input  logic [NUM_BYTES-1:0] dqm_i,
  output logic [DATA_W-1:0]    bit_en_o,
  output logic                 bit_en_vld_o
);
  wpb_pkg::wpb_cmd_t   cmd;
  logic [DATA_W-1:0]    mask_q;
  logic [NUM_BANKS-1:0] flags_q;
  logic                 wpb_on;

  assign cmd = '{act: act_i, wr: wr_i, smrs: smrs_i};

  wpb_mask_reg #(.DATA_W(DATA_W)) u_mask (
    .clk(clk), .rst(rst), .load_i(cmd.smrs), .data_i(dq_i), .mask_o(mask_q)
  );

  wpb_bank_flags #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_flags (
    .clk(clk), .rst(rst), .act_i(cmd.act), .bank_i(bank_i), .dsf_i(dsf_i),
    .flags_o(flags_q)
  );

  always_comb begin
    wpb_on = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_i == BANK_W'(b)) wpb_on = flags_q[b];
  end

  wpb_enable_gen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_en (
    .clk(clk), .rst(rst), .wr_i(cmd.wr), .wpb_on_i(wpb_on), .mask_i(mask_q),
    .dqm_i(dqm_i), .bit_en_o(bit_en_o), .vld_o(bit_en_vld_o)
  );
endmodule

// File: rtl/wpb_mask_checker.sv
module wpb_mask_checker #(
  parameter int DATA_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int NUM_BANKS = 2,
  parameter int NUM_BYTES = 4,
  parameter int BANK_W    = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 act_i,
  input logic                 wr_i,
  input logic                 smrs_i,
  input logic [BANK_W-1:0]    bank_i,
  input logic                 dsf_i,
  input logic [DATA_W-1:0]    dq_i,
  input logic [NUM_BYTES-1:0] dqm_i,
  input logic [DATA_W-1:0]    bit_en_o,
  input logic                 bit_en_vld_o,
  input logic [DATA_W-1:0]    mask_q,
  input logic [NUM_BANKS-1:0] flags_q
);
  logic [DATA_W-1:0] dqm_keep;
  logic              sel_flag;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) dqm_keep[i] = ~dqm_i[i / BYTE_W];
    sel_flag = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_i == BANK_W'(b)) sel_flag = flags_q[b];
  end

  // R1: state after a reset cycle
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (mask_q == '1 && flags_q == '0 && !bit_en_vld_o && bit_en_o == '0));

  // R2
  p_flag_capture_r2: assert property (@(posedge clk) disable iff (rst)
    act_i |=> flags_q[$past(bank_i)] == $past(dsf_i));

  // R3
  p_flag_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !act_i |=> $stable(flags_q));

  // R4
  p_mask_load_r4: assert property (@(posedge clk) disable iff (rst)
    smrs_i |=> mask_q == $past(dq_i));

  // R5: a blocked byte is never enabled
  p_dqm_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (bit_en_o & ~$past(dqm_keep)) == '0);

  // R6
  p_disarmed_bytes_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !sel_flag) |=> bit_en_o == $past(dqm_keep));

  // R7
  p_valid_tracks_r7: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> bit_en_vld_o);

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> (!bit_en_vld_o && bit_en_o == '0));

  // R8: armed write uses the mask held before the cycle
  p_old_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_i && sel_flag) |=> bit_en_o == ($past(mask_q) & $past(dqm_keep)));

  // R9
  p_b2b_beats_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_i && $past(wr_i)) |=> (bit_en_vld_o && $past(bit_en_vld_o)));
endmodule

bind wpb_mask_unit wpb_mask_checker #(
  .DATA_W(DATA_W), .BYTE_W(BYTE_W), .NUM_BANKS(NUM_BANKS),
  .NUM_BYTES(NUM_BYTES), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst(rst), .act_i(act_i), .wr_i(wr_i), .smrs_i(smrs_i),
  .bank_i(bank_i), .dsf_i(dsf_i), .dq_i(dq_i), .dqm_i(dqm_i),
  .bit_en_o(bit_en_o), .bit_en_vld_o(bit_en_vld_o),
  .mask_q(mask_q), .flags_q(flags_q)
);

// File: tb/tb_wpb_mask_unit.sv
module tb_wpb_mask_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          act_i = 0, wr_i = 0, smrs_i = 0, dsf_i = 0;
  logic [0:0]    bank_i = '0;
  logic [DW-1:0] dq_i = '0;
  logic [NB-1:0] dqm_i = '0;
  logic [DW-1:0] bit_en_o;
  logic          bit_en_vld_o;

  int n_checks = 0;
  int n_fail   = 0;
  string last_req = "R1";

  wpb_mask_unit dut (
    .clk(clk), .rst(rst), .act_i(act_i), .wr_i(wr_i), .smrs_i(smrs_i),
    .bank_i(bank_i), .dsf_i(dsf_i), .dq_i(dq_i), .dqm_i(dqm_i),
    .bit_en_o(bit_en_o), .bit_en_vld_o(bit_en_vld_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  bit            m_flag[2];
  logic [DW-1:0] m_mask;
  logic [DW-1:0] exp_en;
  logic          exp_vld;

  always @(posedge clk) begin
    if (rst) begin
      m_flag[0] = 0; m_flag[1] = 0;
      m_mask  = '1;
      exp_en  = '0;
      exp_vld = 0;
    end else begin
      exp_vld = wr_i;
      exp_en  = '0;
      if (wr_i) begin
        for (int i = 0; i < DW; i++)
          exp_en[i] = !dqm_i[i/8] && (m_flag[bank_i] ? m_mask[i] : 1'b1);
      end
      if (smrs_i) m_mask = dq_i;
      if (act_i)  m_flag[bank_i] = dsf_i;
    end
  end

  task automatic check_now();
    n_checks++;
    if (bit_en_o !== exp_en || bit_en_vld_o !== exp_vld) begin
      n_fail++;
      $display("FAIL %s: en=%h vld=%b expected en=%h vld=%b",
               last_req, bit_en_o, bit_en_vld_o, exp_en, exp_vld);
    end
  endtask

  task automatic cyc(input string req, input logic a, input logic w, input logic s,
                     input logic bk, input logic d, input logic [DW-1:0] dq,
                     input logic [NB-1:0] m);
    @(negedge clk);
    check_now();
    last_req = req;
    act_i = a; wr_i = w; smrs_i = s; bank_i = bk; dsf_i = d; dq_i = dq; dqm_i = m;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    n_checks++;
    if (bit_en_o !== '0 || bit_en_vld_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: en=%h vld=%b expected en=0 vld=0", bit_en_o, bit_en_vld_o);
    end
    rst = 0;
    // R6: disarmed bank, byte masks only
    cyc("R6", 0,1,0, 0,0, '0, 4'b0000);
    cyc("R6", 0,1,0, 0,0, '0, 4'b1010);
    // R1: arm bank 0 before loading the mask -> reset mask is all ones
    cyc("R2", 1,0,0, 0,1, '0, 4'b0000);
    cyc("R1", 0,1,0, 0,0, '0, 4'b0000);
    // R4: load mask, then write
    cyc("R4", 0,0,1, 0,0, 32'hF0F0_1234, 4'b0000);
    cyc("R4", 0,1,0, 0,0, '0, 4'b0000);
    // R5: mask combined with byte masks
    cyc("R5", 0,1,0, 0,0, '0, 4'b0101);
    // R3: bank 1 untouched by the bank 0 activate
    cyc("R3", 0,1,0, 1,0, '0, 4'b0000);
    // R9: burst of back-to-back beats
    cyc("R9", 0,1,0, 0,0, '0, 4'b0001);
    cyc("R9", 0,1,0, 0,0, '0, 4'b0010);
    cyc("R9", 0,1,0, 0,0, '0, 4'b0100);
    cyc("R9", 0,1,0, 0,0, '0, 4'b1000);
    // R7: idle cycles
    cyc("R7", 0,0,0, 0,0, 32'hDEAD_BEEF, 4'b0000);
    cyc("R7", 0,0,0, 1,1, '0, 4'b1111);
    // R2: disarm bank 0
    cyc("R2", 1,0,0, 0,0, '0, 4'b0000);
    cyc("R2", 0,1,0, 0,0, '0, 4'b0000);
    // R8: load and write in the same cycle
    cyc("R2", 1,0,0, 0,1, '0, 4'b0000);
    cyc("R8", 0,1,1, 0,0, 32'h0000_FFFF, 4'b0000);
    cyc("R8", 0,1,0, 0,0, '0, 4'b0000);
    // R8: activate and write to the same bank in one cycle
    cyc("R8", 1,1,0, 1,1, '0, 4'b0000);
    cyc("R8", 0,1,0, 1,0, '0, 4'b0000);
    cyc("R3", 1,0,0, 1,0, '0, 4'b0000);
    cyc("R3", 0,1,0, 0,0, '0, 4'b0000);
    // R5: random command mix
    for (int k = 0; k < 400; k++)
      cyc("R5", 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), $urandom, 4'($urandom));
    cyc("R7", 0,0,0, 0,0, '0, 4'b0000);
    cyc("R7", 0,0,0, 0,0, '0, 4'b0000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule